// File: doc/BRIEF.md
# Single-Channel DMA Address and Count Engine

This block is the per-transfer datapath of one DMA channel. It keeps a 16-bit current address, a 16-bit current count and an 8-bit page value. For every accepted transfer it presents a 24-bit physical address, then steps the address and decrements the count. Terminal count is flagged during the transfer in which the count passes zero. The channel can move bytes or 16-bit words, selected by a width pin. A surrounding register decoder drives one-cycle load pulses with a shared data word. A device request arrives as a valid/ready handshake.

The handshake rules are as follows. `req_ready` is high whenever the channel is armed (not stopped and not in cascade). It never depends on `req_valid`. A transfer takes place in every cycle where both are high. The address and terminal-count flag shown in that cycle belong to that transfer. The device holds `req_valid` while `req_ready` is low. In single mode each handshake cycle is exactly one transfer.

The count is loaded as the number of transfers minus one. The page value never changes on its own. Transfers therefore wrap inside a 64 KB window in byte mode or a 128 KB window in word mode.

Top module: `dma_xfer_engine`

## Requirements
- R1: After reset the current address, remaining count and page are zero, `req_ready` is low (channel stopped), and `hold_req`, `dev_ack` and `term_cnt` are low.
- R2: In byte mode (`wide_mode`=0) `phys_addr` equals {page[7:0], address[15:0]}.
- R3: In word mode (`wide_mode`=1) `phys_addr` equals {page[7:1], address[15:0], 0}, so page bit 0 has no effect.
- R4: Each transfer presents the current address and then moves it by one. The move is an increment when mode bit 5 is 0 and a decrement when mode bit 5 is 1.
- R5: Only the 16-bit address wraps (0xFFFF+1 gives 0x0000, 0x0000-1 gives 0xFFFF). The page never changes except through its load pulse.
- R6: A loaded count of N-1 yields exactly N transfers. `term_cnt` is high during the transfer in which the count is 0x0000.
- R7: After terminal count with auto-init clear (mode bit 4 = 0), `req_ready` stays low and `rem_cnt` reads 0xFFFF until the count is loaded again.
- R8: With auto-init set (mode bit 4 = 1), terminal count reloads the current address and count from the values last loaded, and `req_ready` stays high.
- R9: Mode bits [3:2] give direction: 01 drives `to_mem` high (0x44 is I/O-to-memory), and 10 drives `from_mem` high (0x48 is memory-to-I/O).
- R10: Mode bits [7:6]=11 (for example 0xC0) select cascade. In cascade `hold_req` follows `req_valid` and `dev_ack` follows `hold_ack`. `req_ready` is low and the address does not move.
- R11: While `req_valid` is low, the address and count are unchanged, and `req_ready` still shows whether the channel is armed.
- R12: When an address or count load and a transfer fall in the same cycle, the loaded value wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wide_mode | input | 1 | 1 = 16-bit word transfers, 0 = byte transfers |
| ld_addr | input | 1 | Load base and current address from wr_data |
| ld_cnt | input | 1 | Load base and current count from wr_data; re-arms the channel |
| ld_page | input | 1 | Load page from wr_data[7:0] |
| ld_mode | input | 1 | Load mode from wr_data[7:0] |
| wr_data | input | 16 | Load data word |
| req_valid | input | 1 | Device transfer request |
| req_ready | output | 1 | Channel armed to accept a transfer |
| phys_addr | output | 24 | Physical address of the current transfer |
| term_cnt | output | 1 | High during the transfer that ends the count |
| to_mem | output | 1 | Direction: I/O to memory |
| from_mem | output | 1 | Direction: memory to I/O |
| hold_ack | input | 1 | Hold acknowledge from the bus side (cascade) |
| hold_req | output | 1 | Hold request passed through in cascade |
| dev_ack | output | 1 | Device acknowledge passed through in cascade |
| rem_cnt | output | 16 | Current count readback (remaining transfers minus one) |

## Verification
The bench targets the 16-bit wrap in both directions. A design that carried into the page would show a shifted page in the address after 0xFFFF or 0x0000. Word mode is checked with an odd page, so a design that kept page bit 0 or forgot the shift gives an address off by 64 KB or halved. Several counts are tested, including a single transfer, to find off-by-one errors in the N-1 rule. Other cases: a stop that fails to drop ready, an auto-init that fails to restore the base address, a cascade that still produces transfers, and a transfer that overrides a same-cycle load.

// File: rtl/dma_eng_pkg.sv
package dma_eng_pkg;

  typedef struct packed {
    logic casc;
    logic dec;
    logic autoi;
    logic from_mem;
    logic to_mem;
  } mode_t;

  function automatic mode_t decode_mode(input logic [7:0] m);
    mode_t r;
    r.casc     = (m[7:6] == 2'b11);
    r.dec      = m[5];
    r.autoi    = m[4];
    r.from_mem = (m[3:2] == 2'b10);
    r.to_mem   = (m[3:2] == 2'b01);
    return r;
  endfunction

endpackage

// File: rtl/dma_mode_reg.sv
module dma_mode_reg
  import dma_eng_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ld,
  input  logic [7:0] mode_in,
  output mode_t      mode
);

  always_ff @(posedge clk) begin
    if (!rst_n)  mode <= '0;
    else if (ld) mode <= decode_mode(mode_in);
  end

endmodule

// File: rtl/dma_addr_ctr.sv
module dma_addr_ctr #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld,
  input  logic [AW-1:0] ld_val,
  input  logic          step,
  input  logic          dec,
  input  logic          reload,
  output logic [AW-1:0] cur
);

  logic [AW-1:0] base;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base <= '0;
      cur  <= '0;
    end else if (ld) begin
      base <= ld_val;
      cur  <= ld_val;
    end else if (reload) begin
      cur <= base;
    end else if (step) begin
      cur <= dec ? cur - AW'(1) : cur + AW'(1);
    end
  end

  // R4
  addr_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !ld && !reload && !dec) |=> (cur == AW'($past(cur) + AW'(1))));

  // R8
  addr_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reload && !ld) |=> (cur == $past(base)));

endmodule

// File: rtl/dma_cnt_ctr.sv
module dma_cnt_ctr #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld,
  input  logic [CW-1:0] ld_val,
  input  logic          step,
  input  logic          autoi,
  output logic [CW-1:0] cur,
  output logic          at_zero,
  output logic          reload
);

  logic [CW-1:0] base;

  assign at_zero = (cur == '0);
  assign reload  = step && at_zero && autoi;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base <= '0;
      cur  <= '0;
    end else if (ld) begin
      base <= ld_val;
      cur  <= ld_val;
    end else if (reload) begin
      cur <= base;
    end else if (step) begin
      cur <= cur - CW'(1);
    end
  end

  // R6
  cnt_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !ld && !reload) |=> (cur == CW'($past(cur) - CW'(1))));

  // R11
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !ld) |=> $stable(cur));

endmodule

// File: rtl/dma_xfer_engine.sv
module dma_xfer_engine
  import dma_eng_pkg::*;
#(
  parameter int AW = 16,
  parameter int CW = 16,
  parameter int PW = 8,
  localparam int PHW = PW + AW
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wide_mode,
  input  logic           ld_addr,
  input  logic           ld_cnt,
  input  logic           ld_page,
  input  logic           ld_mode,
  input  logic [15:0]    wr_data,
  input  logic           req_valid,
  output logic           req_ready,
  output logic [PHW-1:0] phys_addr,
  output logic           term_cnt,
  output logic           to_mem,
  output logic           from_mem,
  input  logic           hold_ack,
  output logic           hold_req,
  output logic           dev_ack,
  output logic [CW-1:0]  rem_cnt
);

  mode_t          mode;
  logic [AW-1:0]  cur_addr;
  logic [CW-1:0]  cur_cnt;
  logic [PW-1:0]  page_q;
  logic           at_zero;
  logic           reload;
  logic           stopped;
  logic           fire;

  dma_mode_reg u_mode (
    .clk     (clk),
    .rst_n   (rst_n),
    .ld      (ld_mode),
    .mode_in (wr_data[7:0]),
    .mode    (mode)
  );

  assign req_ready = !stopped && !mode.casc;
  assign fire      = req_valid && req_ready;

  dma_addr_ctr #(.AW(AW)) u_addr (
    .clk    (clk),
    .rst_n  (rst_n),
    .ld     (ld_addr),
    .ld_val (wr_data[AW-1:0]),
    .step   (fire),
    .dec    (mode.dec),
    .reload (reload),
    .cur    (cur_addr)
  );

  dma_cnt_ctr #(.CW(CW)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .ld      (ld_cnt),
    .ld_val  (wr_data[CW-1:0]),
    .step    (fire),
    .autoi   (mode.autoi),
    .cur     (cur_cnt),
    .at_zero (at_zero),
    .reload  (reload)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)       page_q <= '0;
    else if (ld_page) page_q <= wr_data[PW-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                             stopped <= 1'b1;
    else if (ld_cnt)                        stopped <= 1'b0;
    else if (fire && at_zero && !mode.autoi) stopped <= 1'b1;
  end

  generate
    if (PW > 1) begin : g_map
      always_comb begin
        if (wide_mode) phys_addr = {page_q[PW-1:1], cur_addr, 1'b0};
        else           phys_addr = {page_q, cur_addr};
      end
    end else begin : g_map1
      always_comb begin
        if (wide_mode) phys_addr = {cur_addr, 1'b0};
        else           phys_addr = {page_q, cur_addr};
      end
    end
  endgenerate

  assign term_cnt = fire && at_zero;
  assign to_mem   = mode.to_mem;
  assign from_mem = mode.from_mem;
  assign hold_req = mode.casc && req_valid;
  assign dev_ack  = mode.casc && hold_ack;
  assign rem_cnt  = cur_cnt;

  // R7
  stop_after_tc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (term_cnt && !mode.autoi && !ld_cnt) |=> !req_ready);

  // R5
  page_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_page |=> $stable(page_q));

  // R10
  casc_no_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode.casc && !ld_addr && !ld_mode) |=> $stable(cur_addr));

endmodule

// File: tb/dma_xfer_engine_test.sv
module dma_xfer_engine_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wide_mode = 1'b0;
  logic        ld_addr = 1'b0, ld_cnt = 1'b0, ld_page = 1'b0, ld_mode = 1'b0;
  logic [15:0] wr_data = '0;
  logic        req_valid = 1'b0;
  logic        hold_ack = 1'b0;
  logic        req_ready, term_cnt, to_mem, from_mem, hold_req, dev_ack;
  logic [23:0] phys_addr;
  logic [15:0] rem_cnt;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  dma_xfer_engine uut (
    .clk(clk), .rst_n(rst_n), .wide_mode(wide_mode),
    .ld_addr(ld_addr), .ld_cnt(ld_cnt), .ld_page(ld_page), .ld_mode(ld_mode),
    .wr_data(wr_data), .req_valid(req_valid), .req_ready(req_ready),
    .phys_addr(phys_addr), .term_cnt(term_cnt), .to_mem(to_mem),
    .from_mem(from_mem), .hold_ack(hold_ack), .hold_req(hold_req),
    .dev_ack(dev_ack), .rem_cnt(rem_cnt)
  );

  typedef struct packed {
    logic        wide;
    logic [7:0]  mode;
    logic [7:0]  page;
    logic [15:0] addr;
    logic [15:0] cnt;
    logic [7:0]  steps;
    logic [23:0] last_phys;
    logic        tc;
    logic [15:0] rem;
    logic        rdy;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 8'h44, 8'h12, 16'h3456, 16'd2,    8'd3, 24'h123458, 1'b1, 16'hFFFF, 1'b0},
    '{1'b1, 8'h48, 8'h13, 16'h8000, 16'd0,    8'd1, 24'h130000, 1'b1, 16'hFFFF, 1'b0},
    '{1'b0, 8'h44, 8'h05, 16'hFFFE, 16'd3,    8'd3, 24'h050000, 1'b0, 16'h0000, 1'b1},
    '{1'b0, 8'h64, 8'h20, 16'h0001, 16'd5,    8'd3, 24'h20FFFF, 1'b0, 16'h0002, 1'b1},
    '{1'b0, 8'h54, 8'h01, 16'h1000, 16'd1,    8'd3, 24'h011000, 1'b0, 16'h0000, 1'b1},
    '{1'b1, 8'h68, 8'hFF, 16'h0000, 16'h0010, 8'd2, 24'hFFFFFE, 1'b0, 16'h000E, 1'b1}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic load(input logic a, input logic c, input logic p, input logic m,
                      input logic [15:0] d);
    @(negedge clk);
    ld_addr = a; ld_cnt = c; ld_page = p; ld_mode = m; wr_data = d;
    @(negedge clk);
    ld_addr = 1'b0; ld_cnt = 1'b0; ld_page = 1'b0; ld_mode = 1'b0;
  endtask

  logic [23:0] seen_phys;
  logic        seen_tc;

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R1 addr", {8'h0, phys_addr}, 32'h0);
    chk("R1 count", {16'h0, rem_cnt}, 32'h0);
    chk("R1 ready", {31'h0, req_ready}, 32'h0);
    chk("R1 hold/ack/tc", {29'h0, hold_req, dev_ack, term_cnt}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      wide_mode = VECS[i].wide;
      load(1'b0, 1'b0, 1'b0, 1'b1, {8'h0, VECS[i].mode});
      load(1'b0, 1'b0, 1'b1, 1'b0, {8'h0, VECS[i].page});
      load(1'b1, 1'b0, 1'b0, 1'b0, VECS[i].addr);
      load(1'b0, 1'b1, 1'b0, 1'b0, VECS[i].cnt);
      for (int s = 0; s < int'(VECS[i].steps); s++) begin
        req_valid = 1'b1;
        #1;
        seen_phys = phys_addr;
        seen_tc   = term_cnt;
        @(negedge clk);
      end
      req_valid = 1'b0;
      #1;
      chk($sformatf("R2/R3/R4/R5 vec%0d last phys", i), {8'h0, seen_phys}, {8'h0, VECS[i].last_phys});
      chk($sformatf("R6/R8 vec%0d tc on last", i), {31'h0, seen_tc}, {31'h0, VECS[i].tc});
      chk($sformatf("R6/R7 vec%0d remaining", i), {16'h0, rem_cnt}, {16'h0, VECS[i].rem});
      chk($sformatf("R7/R8 vec%0d ready", i), {31'h0, req_ready}, {31'h0, VECS[i].rdy});
    end

    // R9 direction decode
    load(1'b0, 1'b0, 1'b0, 1'b1, 16'h0044);
    #1 chk("R9 0x44", {30'h0, to_mem, from_mem}, 32'h2);
    load(1'b0, 1'b0, 1'b0, 1'b1, 16'h0048);
    #1 chk("R9 0x48", {30'h0, to_mem, from_mem}, 32'h1);

    // R11 armed ready with no request, nothing moves
    wide_mode = 1'b0;
    load(1'b0, 1'b0, 1'b1, 1'b0, 16'h0033);
    load(1'b1, 1'b0, 1'b0, 1'b0, 16'h4000);
    load(1'b0, 1'b1, 1'b0, 1'b0, 16'h0007);
    repeat (3) @(negedge clk);
    #1;
    chk("R11 ready idle", {31'h0, req_ready}, 32'h1);
    chk("R11 addr idle", {8'h0, phys_addr}, 32'h334000);
    chk("R11 count idle", {16'h0, rem_cnt}, 32'h7);

    // R12 load beats same-cycle transfer
    @(negedge clk);
    req_valid = 1'b1; ld_addr = 1'b1; wr_data = 16'h0100;
    @(negedge clk);
    req_valid = 1'b0; ld_addr = 1'b0;
    #1 chk("R12 addr load wins", {8'h0, phys_addr}, 32'h330100);

    // R10 cascade
    load(1'b0, 1'b0, 1'b0, 1'b1, 16'h00C0);
    req_valid = 1'b1; hold_ack = 1'b1;
    #1;
    chk("R10 ready low", {31'h0, req_ready}, 32'h0);
    chk("R10 pass-through", {30'h0, hold_req, dev_ack}, 32'h3);
    @(negedge clk);
    req_valid = 1'b0; hold_ack = 1'b0;
    #1;
    chk("R10 addr unmoved", {8'h0, phys_addr}, 32'h330100);
    chk("R10 pass-through off", {30'h0, hold_req, dev_ack}, 32'h0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule